// File: doc/BRIEF.md
# Paged Register Bank with Broadcast Write

This block is the register file that sits behind a byte-wide register bus (address, write data, write strobe, read strobe, read data). The bus is fed by a serial management controller. The address space holds one shared region that is not paged and two paged windows. The receive window keeps four independent copies of its registers, one per receive port. The transmit window keeps two copies, one per transmit port.

Each window has its own control byte, which is not paged. A read-select field in that byte decides which copy a read of the window returns. A separate write-enable mask decides which copies a write into the window updates. Software can therefore program any subset of ports with one bus write and still read each port back on its own.

Register bits come in four kinds: plain read-write storage, self-clearing pulse bits, fixed read-only identification, and sticky event status that clears when it is read. Event status is set by event inputs from the functions the registers serve. Writes to unmapped addresses are dropped. Reads of unmapped addresses return zero.

Top module: `regbank_top`

## Requirements
- R1: The shared region spans 0x00–0x31, the transmit window 0x32–0x3A and the receive window 0x4C–0x7F. Every other address is reserved: it reads 0x00 and writes to it change nothing. `rdata_o` is 0x00 in any cycle where `rd_i` is low, and during a read it carries the addressed byte in the same cycle.
- R2: The receive control byte at 0x4C holds the read select in bits [5:4] and the per-port write enables in bits [3:0]. It reads back as {2'b00, select, enables} and resets to 0x01.
- R3: The transmit control byte at 0x32 holds the read select in bit 4 and the per-port write enables in bits [1:0]. It reads back with bits 7:5 and 3:2 at zero and resets to 0x01.
- R4: A write to a read-write register of a window updates every copy whose enable bit is set, so several copies can be written at once. With an all-zero mask, no copy changes. The window contents also appear on `rx_cfg_o` and `tx_cfg_o`, where copy p, register r sits at bits [(p*RW+r)*8 +: 8].
- R5: A read of a paged register returns the copy named by the read select, whatever the write mask holds.
- R6: Shared addresses 0x00–0x0F are read-write bytes. They reset to 0x00, read back what was written, and appear on `shared_cfg_o` with register i at bits [i*8 +: 8].
- R7: At 0x10, each bit written as 1 appears on `sc_pulse_o` and in read-back for exactly the one cycle after the write, then returns to 0.
- R8: The following registers are read-only and writes to them are ignored:
  - 0x11 returns the identification byte 0x5C.
  - Receive offset 0x56 returns 0xA0 plus the selected port number.
  - Transmit offset 0x38 returns 0xB0 plus the selected port number.
- R9: Event status registers sit at 0x12 (shared, set by `shared_evt_i`), 0x55 (per receive port, set by `rx_evt_i[p*8 +: 8]`) and 0x37 (per transmit port, set by `tx_evt_i[p*8 +: 8]`).
  - A high event bit sets the status bit from the next cycle on.
  - A read returns the status and clears it from the next cycle on. A bit whose event is high in the read cycle stays set.
  - In a window, only the selected copy is cleared.
  - Writes to these registers are ignored.
- R10: Unused addresses inside a region (0x13–0x31, 0x39–0x3A, 0x57–0x7F) read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data, valid in the read cycle |
| shared_evt_i | input | 8 | Event inputs for shared status |
| rx_evt_i | input | 32 | Event inputs, 8 per receive port |
| tx_evt_i | input | 16 | Event inputs, 8 per transmit port |
| sc_pulse_o | output | 8 | Self-clearing pulse bits |
| shared_cfg_o | output | 128 | Shared read-write contents |
| rx_cfg_o | output | 256 | Receive-port read-write contents |
| tx_cfg_o | output | 64 | Transmit-port read-write contents |

## Verification
The hardest case to reach is an event bit that goes high in the very cycle its status register is read. In that cycle the clear and the set contend, and the set must win. This is harder still in a window where only the selected copy may be cleared while the other copies keep gathering events.

Directed cycles drive the event input in the read cycle of both the shared and the receive status registers, with events pending on other ports. A long random phase then mixes the following in every cycle, and a behavioural model is compared against the outputs on every clock:
- control writes with random masks and selects,
- broadcast writes,
- status reads,
- sparse events.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
    localparam logic [7:0] SH_LAST  = 8'h31;
    localparam logic [7:0] TX_FIRST = 8'h32;
    localparam logic [7:0] TX_LAST  = 8'h3A;
    localparam logic [7:0] RX_FIRST = 8'h4C;
    localparam logic [7:0] RX_LAST  = 8'h7F;
    localparam int         OFF_W    = 6;

    typedef struct packed {
        logic             sh;
        logic             tx;
        logic             rx;
        logic [OFF_W-1:0] off;
    } dec_t;
endpackage

// File: rtl/regbank_decode.sv
module regbank_decode
    import regbank_pkg::*;
(
    input  logic [7:0] addr_i,
    output dec_t       dec_o
);
    always_comb begin
        dec_o = '0;
        if (addr_i <= SH_LAST) begin
            dec_o.sh  = 1'b1;
            dec_o.off = addr_i[OFF_W-1:0];
        end else if (addr_i >= TX_FIRST && addr_i <= TX_LAST) begin
            dec_o.tx  = 1'b1;
            dec_o.off = OFF_W'(addr_i - TX_FIRST);
        end else if (addr_i >= RX_FIRST && addr_i <= RX_LAST) begin
            dec_o.rx  = 1'b1;
            dec_o.off = OFF_W'(addr_i - RX_FIRST);
        end
    end
endmodule

// File: rtl/regbank_shared.sv
module regbank_shared
    import regbank_pkg::*;
#(
    parameter int         RW_NUM  = 16,
    parameter logic [7:0] CHIP_ID = 8'h5C
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                hit_i,
    input  logic [OFF_W-1:0]    off_i,
    input  logic                wr_i,
    input  logic                rd_i,
    input  logic [7:0]          wdata_i,
    input  logic [7:0]          evt_i,
    output logic [7:0]          rdata_o,
    output logic [7:0]          sc_o,
    output logic [RW_NUM*8-1:0] cfg_o
);
    localparam int RI_W   = (RW_NUM > 1) ? $clog2(RW_NUM) : 1;
    localparam int SC_OFF = RW_NUM;
    localparam int ID_OFF = RW_NUM + 1;
    localparam int ST_OFF = RW_NUM + 2;

    typedef struct packed {
        logic [RW_NUM-1:0][7:0] rw;
        logic [7:0]             sc;
        logic [7:0]             st;
    } sh_state_t;

    sh_state_t s_d, s_q;
    logic      wr_hit, rd_hit;
    logic      in_rw;
    logic [RI_W-1:0] ridx;

    assign wr_hit = hit_i & wr_i;
    assign rd_hit = hit_i & rd_i;
    assign in_rw  = off_i < OFF_W'(RW_NUM);
    assign ridx   = off_i[RI_W-1:0];

    always_comb begin
        s_d = s_q;
        // self-clearing byte holds a written value for one cycle only
        s_d.sc = (wr_hit && off_i == OFF_W'(SC_OFF)) ? wdata_i : 8'h00;
        // status: clear on read, a same-cycle event wins
        if (rd_hit && off_i == OFF_W'(ST_OFF)) begin
            s_d.st = 8'h00;
        end
        s_d.st = s_d.st | evt_i;
        if (wr_hit && in_rw) begin
            s_d.rw[ridx] = wdata_i;
        end
    end

    always_comb begin
        rdata_o = 8'h00;
        if (rd_hit) begin
            if (in_rw) begin
                rdata_o = s_q.rw[ridx];
            end else if (off_i == OFF_W'(SC_OFF)) begin
                rdata_o = s_q.sc;
            end else if (off_i == OFF_W'(ID_OFF)) begin
                rdata_o = CHIP_ID;
            end else if (off_i == OFF_W'(ST_OFF)) begin
                rdata_o = s_q.st;
            end
        end
    end

    assign sc_o  = s_q.sc;
    assign cfg_o = s_q.rw;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/regbank_window.sv
module regbank_window
    import regbank_pkg::*;
#(
    parameter int         NUM    = 4,
    parameter int         RW_NUM = 8,
    parameter logic [3:0] TAG    = 4'hA
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    hit_i,
    input  logic [OFF_W-1:0]        off_i,
    input  logic                    wr_i,
    input  logic                    rd_i,
    input  logic [7:0]              wdata_i,
    input  logic [NUM*8-1:0]        evt_i,
    output logic [7:0]              rdata_o,
    output logic [NUM*RW_NUM*8-1:0] cfg_o
);
    localparam int SEL_W  = (NUM > 1) ? $clog2(NUM) : 1;
    localparam int RI_W   = (RW_NUM > 1) ? $clog2(RW_NUM) : 1;
    localparam int ST_OFF = RW_NUM + 1;
    localparam int ID_OFF = RW_NUM + 2;

    typedef struct packed {
        logic [SEL_W-1:0]                rsel;
        logic [NUM-1:0]                  wen;
        logic [NUM-1:0][RW_NUM-1:0][7:0] rw;
        logic [NUM-1:0][7:0]             st;
    } win_state_t;

    win_state_t s_d, s_q;
    logic       wr_hit, rd_hit;
    logic       in_rw;
    logic [RI_W-1:0] ridx;

    assign wr_hit = hit_i & wr_i;
    assign rd_hit = hit_i & rd_i;
    assign in_rw  = (off_i != '0) && (off_i <= OFF_W'(RW_NUM));
    assign ridx   = RI_W'(off_i - OFF_W'(1));

    always_comb begin
        s_d = s_q;
        for (int p = 0; p < NUM; p++) begin
            if (rd_hit && off_i == OFF_W'(ST_OFF) && s_q.rsel == SEL_W'(p)) begin
                s_d.st[p] = 8'h00;
            end
            s_d.st[p] = s_d.st[p] | evt_i[p*8 +: 8];
        end
        if (wr_hit) begin
            if (off_i == '0) begin
                s_d.rsel = wdata_i[4 +: SEL_W];
                s_d.wen  = wdata_i[NUM-1:0];
            end else if (in_rw) begin
                for (int p = 0; p < NUM; p++) begin
                    if (s_q.wen[p]) begin
                        s_d.rw[p][ridx] = wdata_i;
                    end
                end
            end
        end
    end

    always_comb begin
        rdata_o = 8'h00;
        if (rd_hit) begin
            if (off_i == '0) begin
                rdata_o[4 +: SEL_W] = s_q.rsel;
                rdata_o[NUM-1:0]    = s_q.wen;
            end else if (in_rw) begin
                rdata_o = s_q.rw[s_q.rsel][ridx];
            end else if (off_i == OFF_W'(ST_OFF)) begin
                rdata_o = s_q.st[s_q.rsel];
            end else if (off_i == OFF_W'(ID_OFF)) begin
                rdata_o = {TAG, 4'(s_q.rsel)};
            end
        end
    end

    assign cfg_o = s_q.rw;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q     <= '0;
            s_q.wen <= NUM'(1);
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/regbank_top.sv
module regbank_top
    import regbank_pkg::*;
#(
    parameter int         NUM_RX    = 4,
    parameter int         NUM_TX    = 2,
    parameter int         SHARED_RW = 16,
    parameter int         RX_RW     = 8,
    parameter int         TX_RW     = 4,
    parameter logic [7:0] CHIP_ID   = 8'h5C
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic [7:0]                 addr_i,
    input  logic [7:0]                 wdata_i,
    input  logic                       wr_i,
    input  logic                       rd_i,
    output logic [7:0]                 rdata_o,
    input  logic [7:0]                 shared_evt_i,
    input  logic [NUM_RX*8-1:0]        rx_evt_i,
    input  logic [NUM_TX*8-1:0]        tx_evt_i,
    output logic [7:0]                 sc_pulse_o,
    output logic [SHARED_RW*8-1:0]     shared_cfg_o,
    output logic [NUM_RX*RX_RW*8-1:0]  rx_cfg_o,
    output logic [NUM_TX*TX_RW*8-1:0]  tx_cfg_o
);
    dec_t       dec;
    logic [7:0] sh_rd, tx_rd, rx_rd;

    regbank_decode u_dec (
        .addr_i (addr_i),
        .dec_o  (dec)
    );

    regbank_shared #(
        .RW_NUM  (SHARED_RW),
        .CHIP_ID (CHIP_ID)
    ) u_shared (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .hit_i   (dec.sh),
        .off_i   (dec.off),
        .wr_i    (wr_i),
        .rd_i    (rd_i),
        .wdata_i (wdata_i),
        .evt_i   (shared_evt_i),
        .rdata_o (sh_rd),
        .sc_o    (sc_pulse_o),
        .cfg_o   (shared_cfg_o)
    );

    regbank_window #(
        .NUM    (NUM_TX),
        .RW_NUM (TX_RW),
        .TAG    (4'hB)
    ) u_tx (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .hit_i   (dec.tx),
        .off_i   (dec.off),
        .wr_i    (wr_i),
        .rd_i    (rd_i),
        .wdata_i (wdata_i),
        .evt_i   (tx_evt_i),
        .rdata_o (tx_rd),
        .cfg_o   (tx_cfg_o)
    );

    regbank_window #(
        .NUM    (NUM_RX),
        .RW_NUM (RX_RW),
        .TAG    (4'hA)
    ) u_rx (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .hit_i   (dec.rx),
        .off_i   (dec.off),
        .wr_i    (wr_i),
        .rd_i    (rd_i),
        .wdata_i (wdata_i),
        .evt_i   (rx_evt_i),
        .rdata_o (rx_rd),
        .cfg_o   (rx_cfg_o)
    );

    assign rdata_o = sh_rd | tx_rd | rx_rd;
endmodule

// File: rtl/regbank_chk.sv
module regbank_chk
    import regbank_pkg::*;
#(
    parameter int         SHARED_RW = 16,
    parameter int         RX_RW     = 8,
    parameter int         TX_RW     = 4,
    parameter logic [7:0] CHIP_ID   = 8'h5C
) (
    input logic       clk_i,
    input logic       rst_ni,
    input logic [7:0] addr_i,
    input logic [7:0] wdata_i,
    input logic       wr_i,
    input logic       rd_i,
    input logic [7:0] rdata_o,
    input logic [7:0] sc_pulse_o
);
    localparam logic [7:0] SC_A = 8'(SHARED_RW);
    localparam logic [7:0] ID_A = 8'(SHARED_RW + 1);

    logic reserved_a, unused_a;
    assign reserved_a = (addr_i > TX_LAST && addr_i < RX_FIRST) || (addr_i > RX_LAST);
    assign unused_a   = (addr_i > 8'(SHARED_RW + 2) && addr_i <= SH_LAST)
                     || (addr_i > TX_FIRST + 8'(TX_RW + 2) && addr_i <= TX_LAST)
                     || (addr_i > RX_FIRST + 8'(RX_RW + 2) && addr_i <= RX_LAST);

    p_idle_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_i |-> rdata_o == 8'h00);

    p_reserved_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && reserved_a) |-> rdata_o == 8'h00);

    p_unused_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && unused_a) |-> rdata_o == 8'h00);

    p_chip_id_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && addr_i == ID_A) |-> rdata_o == CHIP_ID);

    p_sc_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && addr_i == SC_A) |=> sc_pulse_o == $past(wdata_i));

    p_sc_origin_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sc_pulse_o != 8'h00) |-> $past(wr_i && addr_i == SC_A));
endmodule

bind regbank_top regbank_chk #(
    .SHARED_RW (SHARED_RW),
    .RX_RW     (RX_RW),
    .TX_RW     (TX_RW),
    .CHIP_ID   (CHIP_ID)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .wr_i       (wr_i),
    .rd_i       (rd_i),
    .rdata_o    (rdata_o),
    .sc_pulse_o (sc_pulse_o)
);

// File: tb/regbank_top_tb.sv
module regbank_top_tb;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   addr = '0, wdata = '0;
    logic         wr = 1'b0, rd = 1'b0;
    logic [7:0]   rdata;
    logic [7:0]   sev = '0;
    logic [31:0]  rxev = '0;
    logic [15:0]  txev = '0;
    logic [7:0]   sc_pulse;
    logic [127:0] sh_cfg;
    logic [255:0] rx_cfg;
    logic [63:0]  tx_cfg;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    regbank_top u_dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .addr_i       (addr),
        .wdata_i      (wdata),
        .wr_i         (wr),
        .rd_i         (rd),
        .rdata_o      (rdata),
        .shared_evt_i (sev),
        .rx_evt_i     (rxev),
        .tx_evt_i     (txev),
        .sc_pulse_o   (sc_pulse),
        .shared_cfg_o (sh_cfg),
        .rx_cfg_o     (rx_cfg),
        .tx_cfg_o     (tx_cfg)
    );

    // behavioural reference model
    logic [7:0] m_sh [16];
    logic [7:0] m_sc, m_st;
    int         rxsel, txsel;
    logic [3:0] rxwen;
    logic [1:0] txwen;
    logic [7:0] m_rx [4][8];
    logic [7:0] m_rxst [4];
    logic [7:0] m_tx [2][4];
    logic [7:0] m_txst [2];

    task automatic model_reset();
        foreach (m_sh[i]) m_sh[i] = 8'h00;
        m_sc = 8'h00; m_st = 8'h00;
        rxsel = 0; txsel = 0; rxwen = 4'b0001; txwen = 2'b01;
        foreach (m_rx[p, r]) m_rx[p][r] = 8'h00;
        foreach (m_tx[p, r]) m_tx[p][r] = 8'h00;
        foreach (m_rxst[p]) m_rxst[p] = 8'h00;
        foreach (m_txst[p]) m_txst[p] = 8'h00;
    endtask

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        int ai;
        ai = int'(a);
        if (ai <= 'h0F) return m_sh[ai];
        if (ai == 'h10) return m_sc;
        if (ai == 'h11) return 8'h5C;
        if (ai == 'h12) return m_st;
        if (ai <= 'h31) return 8'h00;
        if (ai == 'h32) return {3'b000, 1'(txsel), 2'b00, txwen};
        if (ai >= 'h33 && ai <= 'h36) return m_tx[txsel][ai - 'h33];
        if (ai == 'h37) return m_txst[txsel];
        if (ai == 'h38) return 8'hB0 + 8'(txsel);
        if (ai == 'h4C) return {2'b00, 2'(rxsel), rxwen};
        if (ai >= 'h4D && ai <= 'h54) return m_rx[rxsel][ai - 'h4D];
        if (ai == 'h55) return m_rxst[rxsel];
        if (ai == 'h56) return 8'hA0 + 8'(rxsel);
        return 8'h00;
    endfunction

    task automatic check8(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
        end
    endtask

    // one bus cycle: drive after negedge, compare before posedge, advance model at posedge
    task automatic cyc(input logic w, input logic r, input logic [7:0] a, input logic [7:0] d,
                       input logic [7:0] se, input logic [31:0] re, input logic [15:0] te,
                       input string tag);
        logic [7:0] nsc;
        int ai;
        @(negedge clk);
        wr = w; rd = r; addr = a; wdata = d; sev = se; rxev = re; txev = te;
        #1;
        check8(tag, "rdata", rdata, r ? exp_read(a) : 8'h00);
        check8("R7", "sc_pulse", sc_pulse, m_sc);
        for (int i = 0; i < 16; i++) check8("R6", "shared_cfg", sh_cfg[i*8 +: 8], m_sh[i]);
        for (int p = 0; p < 4; p++)
            for (int k = 0; k < 8; k++) check8("R4", "rx_cfg", rx_cfg[(p*8+k)*8 +: 8], m_rx[p][k]);
        for (int p = 0; p < 2; p++)
            for (int k = 0; k < 4; k++) check8("R4", "tx_cfg", tx_cfg[(p*4+k)*8 +: 8], m_tx[p][k]);
        @(posedge clk);
        ai = int'(a);
        nsc = (w && ai == 'h10) ? d : 8'h00;
        if (r && ai == 'h12) m_st = 8'h00;
        m_st = m_st | se;
        if (r && ai == 'h55) m_rxst[rxsel] = 8'h00;
        for (int p = 0; p < 4; p++) m_rxst[p] = m_rxst[p] | re[p*8 +: 8];
        if (r && ai == 'h37) m_txst[txsel] = 8'h00;
        for (int p = 0; p < 2; p++) m_txst[p] = m_txst[p] | te[p*8 +: 8];
        if (w) begin
            if (ai <= 'h0F) m_sh[ai] = d;
            else if (ai == 'h32) begin txsel = int'(d[4]); txwen = d[1:0]; end
            else if (ai >= 'h33 && ai <= 'h36) begin
                for (int p = 0; p < 2; p++) if (txwen[p]) m_tx[p][ai - 'h33] = d;
            end
            else if (ai == 'h4C) begin rxsel = int'(d[5:4]); rxwen = d[3:0]; end
            else if (ai >= 'h4D && ai <= 'h54) begin
                for (int p = 0; p < 4; p++) if (rxwen[p]) m_rx[p][ai - 'h4D] = d;
            end
        end
        m_sc = nsc;
    endtask

    task automatic wrc(input logic [7:0] a, input logic [7:0] d, input string tag);
        cyc(1'b1, 1'b0, a, d, 8'h00, 32'h0, 16'h0, tag);
    endtask

    task automatic rdc(input logic [7:0] a, input string tag);
        cyc(1'b0, 1'b1, a, 8'h00, 8'h00, 32'h0, 16'h0, tag);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // reset state
        rdc(8'h4C, "R2");
        rdc(8'h32, "R3");
        rdc(8'h00, "R6");
        rdc(8'h11, "R8");
        rdc(8'h12, "R9");
        cyc(1'b0, 1'b0, 8'h4C, 8'h00, 8'h00, 32'h0, 16'h0, "R1");

        // shared read-write storage
        for (int i = 0; i < 16; i++) wrc(8'(i), 8'(8'h11 * i + 3), "R6");
        for (int i = 0; i < 16; i++) rdc(8'(i), "R6");

        // receive broadcast to all ports, then read each
        wrc(8'h4C, 8'h0F, "R2");
        rdc(8'h4C, "R2");
        wrc(8'h4D, 8'h3C, "R4");
        for (int p = 0; p < 4; p++) begin
            wrc(8'h4C, 8'((p << 4) | 0), "R2");
            rdc(8'h4D, "R5");
        end
        // single-port write to port 2
        wrc(8'h4C, 8'h04, "R2");
        wrc(8'h4E, 8'h77, "R4");
        rdc(8'h4E, "R5");
        wrc(8'h4C, 8'h24, "R2");
        rdc(8'h4E, "R5");
        // zero mask updates nothing
        wrc(8'h4C, 8'h30, "R4");
        wrc(8'h4D, 8'hFF, "R4");
        rdc(8'h4D, "R4");
        wrc(8'h4C, 8'h1A, "R2");
        wrc(8'h54, 8'hC3, "R4");
        rdc(8'h54, "R5");

        // transmit window
        wrc(8'h32, 8'h03, "R3");
        wrc(8'h33, 8'h5A, "R4");
        wrc(8'h32, 8'h12, "R3");
        rdc(8'h32, "R3");
        rdc(8'h33, "R5");
        wrc(8'h34, 8'h11, "R4");
        rdc(8'h34, "R5");
        wrc(8'h32, 8'h02, "R3");
        rdc(8'h34, "R5");

        // self-clearing pulse
        wrc(8'h10, 8'hA5, "R7");
        rdc(8'h10, "R7");
        rdc(8'h10, "R7");

        // read-only registers ignore writes
        wrc(8'h11, 8'h00, "R8");
        rdc(8'h11, "R8");
        wrc(8'h56, 8'h00, "R8");
        rdc(8'h56, "R8");
        wrc(8'h32, 8'h11, "R3");
        wrc(8'h38, 8'hFF, "R8");
        rdc(8'h38, "R8");

        // clear-on-read status, shared
        cyc(1'b0, 1'b0, 8'h00, 8'h00, 8'h03, 32'h0, 16'h0, "R9");
        wrc(8'h12, 8'h00, "R9");
        rdc(8'h12, "R9");
        rdc(8'h12, "R9");
        cyc(1'b0, 1'b0, 8'h00, 8'h00, 8'h40, 32'h0, 16'h0, "R9");
        cyc(1'b0, 1'b1, 8'h12, 8'h00, 8'h01, 32'h0, 16'h0, "R9");
        rdc(8'h12, "R9");
        rdc(8'h12, "R9");

        // clear-on-read status, receive: only selected copy clears
        cyc(1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 32'h8100_0200, 16'h0400, "R9");
        wrc(8'h4C, 8'h10, "R9");
        cyc(1'b0, 1'b1, 8'h55, 8'h00, 8'h00, 32'h0000_0800, 16'h0, "R9");
        rdc(8'h55, "R9");
        wrc(8'h4C, 8'h30, "R9");
        rdc(8'h55, "R9");
        rdc(8'h55, "R9");
        rdc(8'h37, "R9");
        rdc(8'h37, "R9");

        // reserved and unused addresses
        wrc(8'h80, 8'hFF, "R1");
        rdc(8'h80, "R1");
        rdc(8'h9F, "R1");
        rdc(8'hFF, "R1");
        rdc(8'h3B, "R1");
        rdc(8'h4B, "R1");
        wrc(8'h13, 8'hEE, "R10");
        rdc(8'h13, "R10");
        rdc(8'h31, "R10");
        rdc(8'h39, "R10");
        rdc(8'h57, "R10");
        rdc(8'h7F, "R10");

        // random mix
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] a;
            int pick;
            pick = int'($urandom_range(0, 9));
            case (pick)
                0: a = 8'($urandom_range(0, 'h13));
                1: a = 8'h4C;
                2: a = 8'h32;
                3: a = 8'($urandom_range('h4D, 'h57));
                4: a = 8'($urandom_range('h33, 'h3A));
                5: a = 8'h55;
                6: a = 8'h37;
                7: a = 8'h12;
                8: a = 8'h10;
                default: a = 8'($urandom);
            endcase
            cyc(1'($urandom), 1'($urandom), a, 8'($urandom),
                ($urandom_range(0, 5) == 0) ? 8'($urandom) : 8'h00,
                ($urandom_range(0, 5) == 0) ? 32'($urandom) : 32'h0,
                ($urandom_range(0, 5) == 0) ? 16'($urandom) : 16'h0,
                "R5");
        end
        cyc(1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 32'h0, 16'h0, "R1");
        finish_run();
    end
endmodule